// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by fetching entries from a two-level translation table kept in ordinary memory. A requester presents the virtual address together with a write flag and a user-mode flag. The page directory location comes from a 20-bit frame number. The walker then reads a directory entry and, for a small-page mapping, a table entry. When the walk ends it pulses either a completion strobe, with the physical address and the page size, or a fault strobe, with a three-bit cause code.

Permission is decided from the read/write and user/supervisor bits of the entries. Supervisor accesses are never refused on permission grounds. On a successful walk the walker marks each entry it used as accessed, and it marks the leaf entry dirty on a write. It does this by writing the updated entry back through the same memory port. The memory port carries one request at a time under a valid/ready handshake, and a separate response strobe returns read data or acknowledges a write.

Top module: `pgwalk_top`

## Requirements
- R1: The first memory access of a walk is a read at address {dir_frame, vaddr[31:22], 2'b00}. Every memory request address is word aligned.
- R2: If directory entry bit 0 (present) is 1 and bit 7 (large) is 0, the second access is a read at {entry[31:12], vaddr[21:12], 2'b00}.
- R3: A successful small-page walk reports paddr = {table_entry[31:12], vaddr[11:0]} with big_page = 0.
- R4: A directory entry with bits 0 and 7 both set maps a 4 MB page. No table read is made, paddr = {dir_entry[31:22], vaddr[21:0]} and big_page = 1.
- R5: An entry whose bit 0 is clear, at either level, ends the walk with fault. fault_code[0] = 0, fault_code[1] = write flag and fault_code[2] = user flag.
- R6: A user access needs bit 2 set in every entry used, and a user write also needs bit 1 set in every entry used. A refused access faults with fault_code = {user, write, 1}.
- R7: A supervisor access ignores bits 1 and 2 of both entries. A supervisor write to a read-only, supervisor-only page succeeds.
- R8: After a successful walk, each entry used whose bit 5 (accessed) was clear is written back with bit 5 set, the directory entry before the table entry. On a write, bit 6 (dirty) is also set in the leaf entry. An entry that would not change is not written, and a faulting walk writes nothing.
- R9: Entry bits 11:9 do not affect the result and are kept unchanged in every write-back.
- R10: A memory request holds its address, write enable and data stable until accepted. Only one request is outstanding at a time. No request is issued while the walker is idle.
- R11: After reset, and one cycle after each done or fault pulse, req_ready is 1. done and fault are single-cycle pulses that never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| dir_frame | input | 20 | Physical frame number of the page directory |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_we | output | 1 | Request is a write-back |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid or write acknowledged |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_code | output | 3 | {user, write, protection} cause of the fault |
| paddr | output | 32 | Translated physical address, valid with done |
| big_page | output | 1 | The mapping used is a 4 MB page |

## Verification
The assertions assume that memory gives exactly one mem_rsp_valid pulse for each accepted request, and never one without an accepted request. They also assume that the response comes no earlier than the cycle after acceptance. The bench memory model follows this by raising ready only while a request is pending and answering one cycle after the handshake. It varies the ready delay between requests, so the hold-until-accepted rule is exercised under stalls. Requests are presented only while req_ready is high. Table contents are changed only between walks, so the bench's prediction from memory at request time stays valid for the whole walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned IDX_W   = 10;
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam int unsigned BIG_W   = OFF_W + IDX_W;
    localparam int unsigned CODE_W  = 3;

    // entry bit positions the walker decodes
    localparam int unsigned BIT_P  = 0;
    localparam int unsigned BIT_RW = 1;
    localparam int unsigned BIT_US = 2;
    localparam int unsigned BIT_A  = 5;
    localparam int unsigned BIT_D  = 6;
    localparam int unsigned BIT_PS = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } st_e;

    typedef enum logic [1:0] {
        PH_DIR_RD = 2'd0,
        PH_TBL_RD = 2'd1,
        PH_DIR_WB = 2'd2,
        PH_TBL_WB = 2'd3
    } ph_e;

    typedef struct packed {
        st_e                st;
        ph_e                ph;
        logic [ADDR_W-1:0]  va;
        logic               wr;
        logic               usr;
        logic [ADDR_W-1:0]  pde;
        logic [ADDR_W-1:0]  pte;
        logic               big;
        logic [ADDR_W-1:0]  maddr;
        logic               mwe;
        logic [ADDR_W-1:0]  mwdata;
        logic [CODE_W-1:0]  fcode;
        logic [ADDR_W-1:0]  pa;
    } walk_s;

    // entry with accessed set, and dirty set on a write
    function automatic logic [ADDR_W-1:0] mark_used(input logic [ADDR_W-1:0] e,
                                                    input logic wr);
        logic [ADDR_W-1:0] r;
        r = e;
        r[BIT_A] = 1'b1;
        if (wr) r[BIT_D] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
(
    input  logic [FRAME_W-1:0] base_frame,
    input  logic [ADDR_W-1:0]  va,
    input  logic [FRAME_W-1:0] dir_ent_frame,
    input  logic [FRAME_W-1:0] tbl_ent_frame,
    output logic [ADDR_W-1:0]  dir_ea,
    output logic [ADDR_W-1:0]  tbl_ea,
    output logic [ADDR_W-1:0]  pa_small,
    output logic [ADDR_W-1:0]  pa_big
);
    localparam int unsigned HI_IDX_LSB = OFF_W + IDX_W;

    always_comb begin
        dir_ea   = {base_frame, va[ADDR_W-1:HI_IDX_LSB], 2'b00};
        tbl_ea   = {dir_ent_frame, va[HI_IDX_LSB-1:OFF_W], 2'b00};
        pa_small = {tbl_ent_frame, va[OFF_W-1:0]};
        pa_big   = {dir_ent_frame[FRAME_W-1:IDX_W], va[BIG_W-1:0]};
    end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
    input  logic pde_us,
    input  logic pde_rw,
    input  logic pte_us,
    input  logic pte_rw,
    input  logic big,
    input  logic wr,
    input  logic usr,
    output logic allow
);
    logic user_ok;
    logic write_ok;

    always_comb begin
        user_ok  = pde_us & (big | pte_us);
        write_ok = pde_rw & (big | pte_rw);
        allow    = !usr || (user_ok && (!wr || write_ok));
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic                req_write,
    input  logic                req_user,
    input  logic [FRAME_W-1:0]  dir_frame,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic                mem_req_we,
    output logic [ADDR_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [ADDR_W-1:0]   mem_rsp_data,
    output logic                done,
    output logic                fault,
    output logic [CODE_W-1:0]   fault_code,
    output logic [ADDR_W-1:0]   paddr,
    output logic                big_page
);
    walk_s q, d;

    logic [ADDR_W-1:0] va_eff;
    logic [ADDR_W-1:0] pde_eff;
    logic [ADDR_W-1:0] pte_eff;
    logic [ADDR_W-1:0] dir_ea, tbl_ea, pa_small, pa_big;
    logic              perm_big;
    logic              allow;
    logic [ADDR_W-1:0] pde_upd;
    logic [ADDR_W-1:0] pte_upd;

    always_comb begin
        va_eff   = (q.st == ST_IDLE) ? req_vaddr : q.va;
        pde_eff  = (q.ph == PH_DIR_RD) ? mem_rsp_data : q.pde;
        pte_eff  = (q.ph == PH_TBL_RD) ? mem_rsp_data : q.pte;
        perm_big = (q.ph == PH_DIR_RD);
        pde_upd  = mark_used(pde_eff, q.wr);
        pte_upd  = mark_used(pte_eff, q.wr);
    end

    pgwalk_addr addr_i (
        .base_frame    (dir_frame),
        .va            (va_eff),
        .dir_ent_frame (pde_eff[ADDR_W-1:OFF_W]),
        .tbl_ent_frame (pte_eff[ADDR_W-1:OFF_W]),
        .dir_ea        (dir_ea),
        .tbl_ea        (tbl_ea),
        .pa_small      (pa_small),
        .pa_big        (pa_big)
    );

    pgwalk_perm perm_i (
        .pde_us (pde_eff[BIT_US]),
        .pde_rw (pde_eff[BIT_RW]),
        .pte_us (pte_eff[BIT_US]),
        .pte_rw (pte_eff[BIT_RW]),
        .big    (perm_big),
        .wr     (q.wr),
        .usr    (q.usr),
        .allow  (allow)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.big   = 1'b0;
                    d.st    = ST_REQ;
                    d.ph    = PH_DIR_RD;
                    d.maddr = dir_ea;
                    d.mwe   = 1'b0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (q.ph)
                        PH_DIR_RD: begin
                            d.pde = mem_rsp_data;
                            if (!mem_rsp_data[BIT_P]) begin
                                d.st    = ST_FAULT;
                                d.fcode = {q.usr, q.wr, 1'b0};
                            end else if (mem_rsp_data[BIT_PS]) begin
                                d.big = 1'b1;
                                if (!allow) begin
                                    d.st    = ST_FAULT;
                                    d.fcode = {q.usr, q.wr, 1'b1};
                                end else begin
                                    d.pa = pa_big;
                                    if (pde_upd != mem_rsp_data) begin
                                        d.st     = ST_REQ;
                                        d.ph     = PH_DIR_WB;
                                        d.mwe    = 1'b1;
                                        d.mwdata = pde_upd;
                                    end else begin
                                        d.st = ST_DONE;
                                    end
                                end
                            end else begin
                                d.big   = 1'b0;
                                d.st    = ST_REQ;
                                d.ph    = PH_TBL_RD;
                                d.maddr = tbl_ea;
                                d.mwe   = 1'b0;
                            end
                        end
                        PH_TBL_RD: begin
                            d.pte = mem_rsp_data;
                            if (!mem_rsp_data[BIT_P]) begin
                                d.st    = ST_FAULT;
                                d.fcode = {q.usr, q.wr, 1'b0};
                            end else if (!allow) begin
                                d.st    = ST_FAULT;
                                d.fcode = {q.usr, q.wr, 1'b1};
                            end else begin
                                d.pa = pa_small;
                                if (!q.pde[BIT_A]) begin
                                    d.st     = ST_REQ;
                                    d.ph     = PH_DIR_WB;
                                    d.maddr  = dir_ea;
                                    d.mwe    = 1'b1;
                                    d.mwdata = q.pde | (ADDR_W'(1) << BIT_A);
                                end else if (pte_upd != mem_rsp_data) begin
                                    d.st     = ST_REQ;
                                    d.ph     = PH_TBL_WB;
                                    d.mwe    = 1'b1;
                                    d.mwdata = pte_upd;
                                end else begin
                                    d.st = ST_DONE;
                                end
                            end
                        end
                        PH_DIR_WB: begin
                            if (!q.big && (pte_upd != q.pte)) begin
                                d.st     = ST_REQ;
                                d.ph     = PH_TBL_WB;
                                d.maddr  = tbl_ea;
                                d.mwe    = 1'b1;
                                d.mwdata = pte_upd;
                            end else begin
                                d.st = ST_DONE;
                            end
                        end
                        default: begin
                            d.st = ST_DONE;
                        end
                    endcase
                end
            end
            ST_DONE:  d.st = ST_IDLE;
            ST_FAULT: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        req_ready     = (q.st == ST_IDLE);
        mem_req_valid = (q.st == ST_REQ);
        mem_req_addr  = q.maddr;
        mem_req_we    = q.mwe;
        mem_req_wdata = q.mwdata;
        done          = (q.st == ST_DONE);
        fault         = (q.st == ST_FAULT);
        fault_code    = q.fcode;
        paddr         = q.pa;
        big_page      = q.big;
    end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_req_we,
    input logic [31:0] mem_req_wdata,
    input logic        done,
    input logic        fault,
    input logic        code_user,
    input logic        code_prot
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));                       // R1

    AST_WB_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[5] && mem_req_wdata[0])); // R8

    AST_SUP_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !code_user) |-> !code_prot);                                 // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)));                // R10

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);                  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);                                         // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));                                        // R11

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!fault && req_ready));                                      // R11

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));                                                     // R11
endmodule

bind pgwalk_top pgwalk_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_req_wdata (mem_req_wdata),
    .done          (done),
    .fault         (fault),
    .code_user     (fault_code[2]),
    .code_prot     (fault_code[0])
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] dir_frame = 20'h00100;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [2:0]  fault_code;
    logic [31:0] paddr;
    logic        big_page;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .dir_frame(dir_frame),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_we(mem_req_we),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_code(fault_code), .paddr(paddr), .big_page(big_page)
    );

    // behavioural memory and expected transaction list
    logic [31:0] mem [logic [31:0]];
    logic [31:0] ex_addr[$];
    logic        ex_we[$];
    logic [31:0] ex_data[$];
    string       ex_tag[$];
    logic        ex_fault;
    logic [2:0]  ex_code;
    logic [31:0] ex_pa;
    logic        ex_big;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic push_op(logic [31:0] a, logic we, logic [31:0] dat, string tag);
        ex_addr.push_back(a); ex_we.push_back(we); ex_data.push_back(dat); ex_tag.push_back(tag);
    endtask

    task automatic predict(logic [31:0] va, logic wr, logic usr);
        logic [31:0] da, ta, de, te, nd, nt;
        logic ok;
        ex_fault = 1'b0; ex_code = 3'b000; ex_pa = '0; ex_big = 1'b0;
        da = {dir_frame, 12'h000} + {20'h0, va[31:22], 2'b00};
        push_op(da, 1'b0, 32'h0, "R1");
        de = rd(da);
        if (de[0] == 1'b0) begin
            ex_fault = 1'b1; ex_code = {usr, wr, 1'b0}; return;
        end
        if (de[7]) begin
            ex_big = 1'b1;
            ok = !usr || (de[2] && (!wr || de[1]));
            if (!ok) begin ex_fault = 1'b1; ex_code = {usr, wr, 1'b1}; return; end
            ex_pa = {de[31:22], va[21:0]};
            nd = de | 32'h20 | (wr ? 32'h40 : 32'h0);
            if (nd != de) push_op(da, 1'b1, nd, "R8");
            return;
        end
        ta = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        push_op(ta, 1'b0, 32'h0, "R2");
        te = rd(ta);
        if (te[0] == 1'b0) begin
            ex_fault = 1'b1; ex_code = {usr, wr, 1'b0}; return;
        end
        ok = !usr || ((de[2] && te[2]) && (!wr || (de[1] && te[1])));
        if (!ok) begin ex_fault = 1'b1; ex_code = {usr, wr, 1'b1}; return; end
        ex_pa = {te[31:12], va[11:0]};
        if (de[5] == 1'b0) push_op(da, 1'b1, de | 32'h20, "R8");
        nt = te | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nt != te) push_op(ta, 1'b1, nt, "R8");
    endtask

    // memory responder: ready after a varying delay, response one cycle after handshake
    logic        hs_pend = 1'b0;
    logic [31:0] cap_addr, cap_data;
    logic        cap_we;
    int          delay = 0;
    int          delay_seed = 0;
    always @(negedge clk) begin
        if (hs_pend) begin
            mem_req_ready <= 1'b0;
            hs_pend <= 1'b0;
            if (ex_addr.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: actual=unexpected request at %h expected=none", cap_addr);
            end else begin
                string t;
                logic [31:0] ea, ed;
                logic ew;
                ea = ex_addr.pop_front(); ew = ex_we.pop_front();
                ed = ex_data.pop_front(); t = ex_tag.pop_front();
                check({t, " addr"}, cap_addr, ea);
                check({t, " we"}, {31'h0, cap_we}, {31'h0, ew});
                if (ew) check({t, " wdata"}, cap_data, ed);
            end
            if (cap_we) mem[cap_addr] = cap_data;
            mem_rsp_data  <= cap_we ? 32'h0 : rd(cap_addr);
            mem_rsp_valid <= 1'b1;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
        end else if (mem_req_valid) begin
            if (delay > 0) delay <= delay - 1;
            else begin
                mem_req_ready <= 1'b1;
                hs_pend  <= 1'b1;
                cap_addr <= mem_req_addr;
                cap_we   <= mem_req_we;
                cap_data <= mem_req_wdata;
                delay_seed <= delay_seed + 1;
                delay <= (delay_seed % 3);
            end
        end
    end

    task automatic run(logic [31:0] va, logic wr, logic usr, string tag);
        int n;
        predict(va, wr, usr);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!(done || fault) && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) begin
            checks++; errors++;
            $display("FAIL R11: actual=no end of walk expected=done or fault (%s)", tag);
            return;
        end
        check({tag, " fault"}, {31'h0, fault}, {31'h0, ex_fault});
        check("R11 pulse exclusive", {31'h0, done & fault}, 32'h0);
        if (ex_fault) check({tag, " code"}, {29'h0, fault_code}, {29'h0, ex_code});
        else begin
            check({tag, " paddr"}, paddr, ex_pa);
            check({tag, " big_page"}, {31'h0, big_page}, {31'h0, ex_big});
        end
        check("R10 all ops seen", ex_addr.size(), 0);
        @(negedge clk);
        check("R11 ready after end", {31'h0, req_ready}, 32'h1);
        check("R11 end pulse", {31'h0, done | fault}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // directory at frame 0x00100
        mem[32'h0010_0004] = 32'h0020_0007; mem[32'h0020_0004] = 32'h1234_5007;
        mem[32'h0010_0008] = 32'h0FC0_00A7;
        mem[32'h0010_000C] = 32'h0000_0000;
        mem[32'h0010_0010] = 32'h0030_0027; mem[32'h0030_0014] = 32'h0000_0000;
        mem[32'h0010_0014] = 32'h0040_0023; mem[32'h0040_0000] = 32'h5555_5005;
        mem[32'h0010_0018] = 32'h0050_0027; mem[32'h0050_0000] = 32'h6666_6025;
        mem[32'h0010_001C] = 32'h4000_0081;
        mem[32'h0010_0020] = 32'h0060_0E07; mem[32'h0060_0008] = 32'h7777_7E07;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset ready", {31'h0, req_ready}, 32'h1);
        check("R11 reset done", {31'h0, done}, 32'h0);
        check("R11 reset fault", {31'h0, fault}, 32'h0);
        check("R10 reset mem idle", {31'h0, mem_req_valid}, 32'h0);

        run(32'h0040_1234, 1'b0, 1'b0, "R3 small sup read");
        check("R3 known paddr", paddr, 32'h1234_5234);
        check("R8 accessed set in dir", mem[32'h0010_0004], 32'h0020_0027);
        run(32'h0040_1234, 1'b0, 1'b1, "R8 no rewrite");
        run(32'h0040_1ABC, 1'b1, 1'b1, "R6 user write allowed");
        check("R8 dirty leaf", mem[32'h0020_0004], 32'h1234_5067);
        run(32'h0085_4321, 1'b0, 1'b1, "R4 large user read");
        check("R4 known paddr", paddr, 32'h0FC5_4321);
        run(32'h0085_4321, 1'b1, 1'b0, "R4 large sup write");
        run(32'h00C0_0000, 1'b1, 1'b1, "R5 dir absent");
        check("R5 code value", {29'h0, fault_code}, 32'h6);
        run(32'h0100_5000, 1'b0, 1'b0, "R5 table absent");
        run(32'h0140_0010, 1'b0, 1'b1, "R6 dir not user");
        check("R6 code value", {29'h0, fault_code}, 32'h5);
        run(32'h0180_0FFF, 1'b1, 1'b1, "R6 leaf read-only");
        check("R8 no write on fault", mem[32'h0050_0000], 32'h6666_6025);
        run(32'h0180_0FFF, 1'b1, 1'b0, "R7 sup write read-only");
        run(32'h01C0_0040, 1'b1, 1'b0, "R7 sup large read-only");
        run(32'h0200_2008, 1'b1, 1'b1, "R9 avail bits");
        check("R9 dir kept", mem[32'h0010_0020], 32'h0060_0E27);
        check("R9 leaf kept", mem[32'h0060_0008], 32'h7777_7E67);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule